// File: doc/BRIEF.md
# Advanced Load Address Table

This block lets a scheduler hoist a load above stores that might write the same location. When the hoisted (advanced) load issues, it records its destination register number and its word address in a small associative table. From then on every store address is compared with all live entries, and any entry whose address matches is killed. When the program later reaches the point where the load originally stood, it issues a check on the same register. If the entry is still alive, the speculative value is known good and the check retires without touching memory. If the entry is gone, whether killed by a store, replaced, never written or cleared by an earlier check, the block reports that the value must be fixed. A per-check mode bit picks the fix: reissue the load to memory, or branch to recovery code.

The table is direct mapped on the low bits of the register number. The upper bits are kept as a tag and compared on every lookup. Each check retires the entry it hits. The verdict of a check comes out one clock after the check is presented, as exactly one of three one-cycle flags.

Top module: `alat_table`

## Requirements
- R1: After reset every entry is empty. A check of any register then reports the reload verdict (recovery verdict if its mode bit is set), and all response outputs are low while no check is pending.
- R2: A check presented in cycle N produces `rsp_valid` in cycle N+1. `rsp_hit` is set if the register's entry holds a live entry that no store has matched since allocation.
- R3: A store whose full word address equals a live entry's address kills that entry. A later check of that register reports reload when `chk_recover`=0 and recover when `chk_recover`=1.
- R4: A store whose address differs from an entry's address in any bit, including the most significant bit, leaves that entry alive.
- R5: The entry slot is the register number modulo ENTRIES, and the remaining upper bits form a tag. A check whose tag differs from the stored tag misses and leaves the stored entry untouched.
- R6: A new allocation to a slot replaces the old entry. Stores to the old address no longer affect it.
- R7: A check clears the entry it matches, so a second check of the same register without a new allocation misses.
- R8: A store in the same cycle as an allocation to the same address leaves the new entry dead.
- R9: A store in the same cycle as a check that matches the checked entry's address makes that check miss.
- R10: The mode bit only selects between reload and recover on a miss. A hit raises neither.
- R11: An allocation and a check to the same register in one cycle: the check sees the old entry, and the new entry survives the check.
- R12: When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_reload`, `rsp_recover` is high. Otherwise all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Advanced load issues this cycle |
| alloc_reg | input | REG_W | Destination register of the advanced load |
| alloc_addr | input | ADDR_W | Word address of the advanced load |
| store_valid | input | 1 | A store is snooped this cycle |
| store_addr | input | ADDR_W | Word address of the store |
| chk_valid | input | 1 | A check is presented this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_recover | input | 1 | Miss action: 0 reload, 1 branch to recovery |
| rsp_valid | output | 1 | Verdict of last cycle's check is present |
| rsp_hit | output | 1 | Speculative value is good, no memory access |
| rsp_reload | output | 1 | Load must be reissued to memory |
| rsp_recover | output | 1 | Control must go to recovery code |

## Verification
The bench builds the table with ENTRIES=4, REG_W=6 and ADDR_W=16. With four slots, registers one slot apart differ only in tag (r1 and r5, r0 and r8), so tag conflicts occur with small register numbers. The narrow address keeps a store that differs only in the top bit easy to write down. Same-cycle races are driven as single vectors: store with allocate, store with check, and allocate with check.

// File: rtl/alat_pkg.sv
package alat_pkg;

  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_HIT     = 2'd1,
    OUT_RELOAD  = 2'd2,
    OUT_RECOVER = 2'd3
  } chk_out_e;

  // slot a register maps onto (entries is a power of two)
  function automatic int unsigned slot_of(input int unsigned regno, input int unsigned entries);
    return regno % entries;
  endfunction

  // bits of the register number kept for comparison
  function automatic int unsigned tag_of(input int unsigned regno, input int unsigned entries);
    return regno / entries;
  endfunction

  // miss verdict picked by the check's mode bit
  function automatic chk_out_e verdict(input logic live, input logic recover);
    if (live)         return OUT_HIT;
    else if (recover) return OUT_RECOVER;
    else              return OUT_RELOAD;
  endfunction

endpackage

// File: rtl/alat_slot.sv
module alat_slot #(
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_killed,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              clr,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              snoop_hit_o
);

  logic [ADDR_W-1:0] addr_q;

  assign snoop_hit_o = valid_o && snoop_valid && (snoop_addr == addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      addr_q  <= '0;
    end else if (wr_en) begin
      valid_o <= !wr_killed;
      tag_o   <= wr_tag;
      addr_q  <= wr_addr;
    end else if (clr || snoop_hit_o) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/alat_probe.sv
module alat_probe #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                chk_valid,
  input  logic [IDX_W-1:0]    chk_idx,
  input  logic [TAG_W-1:0]    chk_tag,
  input  logic                chk_recover,
  input  logic [ENTRIES-1:0]  valid_vec,
  input  logic [ENTRIES-1:0]  snoop_hit_vec,
  input  logic [TAG_W-1:0]    tag_arr [ENTRIES],
  output logic [ENTRIES-1:0]  clr_vec,
  output alat_pkg::chk_out_e  outcome
);

  logic live;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_clr
    assign clr_vec[i] = chk_valid && (chk_idx == IDX_W'(i)) && (tag_arr[i] == chk_tag);
  end

  assign live = valid_vec[chk_idx] && (tag_arr[chk_idx] == chk_tag) && !snoop_hit_vec[chk_idx];

  always_comb begin
    if (chk_valid) outcome = alat_pkg::verdict(live, chk_recover);
    else           outcome = alat_pkg::OUT_NONE;
  end

endmodule

// File: rtl/alat_table.sv
module alat_table #(
  parameter int ENTRIES = 8,
  parameter int REG_W   = 7,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_recover,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_reload,
  output logic              rsp_recover
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = REG_W - IDX_W;

  logic [IDX_W-1:0]   alloc_idx, chk_idx;
  logic [TAG_W-1:0]   alloc_tag, chk_tag;
  logic               alloc_killed;
  logic [ENTRIES-1:0] wr_vec, clr_vec, valid_vec, snoop_hit_vec;
  logic [TAG_W-1:0]   tag_arr [ENTRIES];
  alat_pkg::chk_out_e outcome;

  assign alloc_idx    = IDX_W'(alat_pkg::slot_of(int'(alloc_reg), ENTRIES));
  assign alloc_tag    = TAG_W'(alat_pkg::tag_of(int'(alloc_reg), ENTRIES));
  assign chk_idx      = IDX_W'(alat_pkg::slot_of(int'(chk_reg), ENTRIES));
  assign chk_tag      = TAG_W'(alat_pkg::tag_of(int'(chk_reg), ENTRIES));
  assign alloc_killed = store_valid && (store_addr == alloc_addr);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign wr_vec[i] = alloc_valid && (alloc_idx == IDX_W'(i));
    alat_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_vec[i]),
      .wr_killed   (alloc_killed),
      .wr_tag      (alloc_tag),
      .wr_addr     (alloc_addr),
      .snoop_valid (store_valid),
      .snoop_addr  (store_addr),
      .clr         (clr_vec[i]),
      .valid_o     (valid_vec[i]),
      .tag_o       (tag_arr[i]),
      .snoop_hit_o (snoop_hit_vec[i])
    );
  end

  alat_probe #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_probe (
    .chk_valid     (chk_valid),
    .chk_idx       (chk_idx),
    .chk_tag       (chk_tag),
    .chk_recover   (chk_recover),
    .valid_vec     (valid_vec),
    .snoop_hit_vec (snoop_hit_vec),
    .tag_arr       (tag_arr),
    .clr_vec       (clr_vec),
    .outcome       (outcome)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_reload  <= 1'b0;
      rsp_recover <= 1'b0;
    end else begin
      rsp_valid   <= (outcome != alat_pkg::OUT_NONE);
      rsp_hit     <= (outcome == alat_pkg::OUT_HIT);
      rsp_reload  <= (outcome == alat_pkg::OUT_RELOAD);
      rsp_recover <= (outcome == alat_pkg::OUT_RECOVER);
    end
  end

endmodule

// File: rtl/alat_checker.sv
module alat_checker #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_valid,
  input logic [ADDR_W-1:0]  alloc_addr,
  input logic               store_valid,
  input logic [ADDR_W-1:0]  store_addr,
  input logic               chk_valid,
  input logic               chk_recover,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_reload,
  input logic               rsp_recover,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] snoop_hit_vec,
  input logic [ENTRIES-1:0] wr_vec,
  input logic [ENTRIES-1:0] clr_vec
);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_reload, rsp_recover}) == 1); // R12
  AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_reload || rsp_recover)); // R12
  AST_RSP_FOLLOWS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> rsp_valid); // R2
  AST_NO_RSP_WITHOUT_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !rsp_valid); // R2
  AST_MODE_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_recover |-> $past(chk_recover)); // R10
  AST_MODE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reload |-> !$past(chk_recover)); // R10
  AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_hit_vec & ~wr_vec) != '0 |=> (valid_vec & $past(snoop_hit_vec & ~wr_vec)) == '0); // R3
  AST_RACE_ALLOC_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && store_valid && alloc_addr == store_addr) |=> (valid_vec & $past(wr_vec)) == '0); // R8
  AST_CHECK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec & ~wr_vec) != '0 |=> (valid_vec & $past(clr_vec & ~wr_vec)) == '0); // R7

endmodule

bind alat_table alat_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_alat_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .alloc_valid   (alloc_valid),
  .alloc_addr    (alloc_addr),
  .store_valid   (store_valid),
  .store_addr    (store_addr),
  .chk_valid     (chk_valid),
  .chk_recover   (chk_recover),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_reload    (rsp_reload),
  .rsp_recover   (rsp_recover),
  .valid_vec     (valid_vec),
  .snoop_hit_vec (snoop_hit_vec),
  .wr_vec        (wr_vec),
  .clr_vec       (clr_vec)
);

// File: tb/tb_alat_table.sv
module tb_alat_table;

  localparam int ENTRIES = 4;
  localparam int REG_W   = 6;
  localparam int ADDR_W  = 16;

  // expected verdict codes: 0 none, 1 hit, 2 reload, 3 recover
  typedef struct packed {
    logic              av;
    logic [REG_W-1:0]  areg;
    logic [ADDR_W-1:0] aaddr;
    logic              sv;
    logic [ADDR_W-1:0] saddr;
    logic              cv;
    logic [REG_W-1:0]  creg;
    logic              crec;
    logic [1:0]        exp;
    logic [3:0]        req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd3,  1'b0, 2'd2, 4'd1},  // R1 empty table
    '{1'b1, 6'd1,  16'h0100, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12}, // R12 idle
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd1,  1'b0, 2'd1, 4'd2},  // R2 hit
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd1,  1'b0, 2'd2, 4'd7},  // R7 cleared
    '{1'b1, 6'd2,  16'h0200, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b1, 16'h0201, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12}, // R4 near miss
    '{1'b0, 6'd0,  16'h0000, 1'b1, 16'h8200, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12}, // R4 msb differs
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd2,  1'b0, 2'd1, 4'd4},  // R4 still live
    '{1'b1, 6'd3,  16'h0300, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b1, 16'h0300, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd3,  1'b1, 2'd3, 4'd10}, // R10 R3 recover
    '{1'b1, 6'd5,  16'h0500, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd1,  1'b0, 2'd2, 4'd5},  // R5 tag miss
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd5,  1'b0, 2'd1, 4'd5},  // R5 untouched
    '{1'b1, 6'd6,  16'h0600, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b1, 6'd6,  16'h0660, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12}, // R6 replace
    '{1'b0, 6'd0,  16'h0000, 1'b1, 16'h0600, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd6,  1'b0, 2'd1, 4'd6},  // R6 old addr ignored
    '{1'b1, 6'd7,  16'h0700, 1'b1, 16'h0700, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12}, // R8 race
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd7,  1'b0, 2'd2, 4'd8},  // R8 dead
    '{1'b1, 6'd8,  16'h0800, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b1, 16'h0800, 1'b1, 6'd8,  1'b1, 2'd3, 4'd9},  // R9 race
    '{1'b1, 6'd9,  16'h0900, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b1, 6'd9,  16'h0990, 1'b0, 16'h0000, 1'b1, 6'd9,  1'b0, 2'd1, 4'd11}, // R11 old seen
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd9,  1'b1, 2'd1, 4'd11}, // R11 new survives
    '{1'b1, 6'd10, 16'h0A00, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b1, 16'h0A00, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12},
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b1, 6'd10, 1'b0, 2'd2, 4'd3},  // R3 reload
    '{1'b0, 6'd0,  16'h0000, 1'b0, 16'h0000, 1'b0, 6'd0,  1'b0, 2'd0, 4'd12}  // R12 quiet
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, store_valid = 1'b0, chk_valid = 1'b0, chk_recover = 1'b0;
  logic [REG_W-1:0]  alloc_reg = '0, chk_reg = '0;
  logic [ADDR_W-1:0] alloc_addr = '0, store_addr = '0;
  logic rsp_valid, rsp_hit, rsp_reload, rsp_recover;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  alat_table #(.ENTRIES(ENTRIES), .REG_W(REG_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .store_valid(store_valid), .store_addr(store_addr),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_recover(chk_recover),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_reload(rsp_reload), .rsp_recover(rsp_recover)
  );

  function automatic logic [3:0] expand(input logic [1:0] code);
    case (code)
      2'd1:    return 4'b1100;
      2'd2:    return 4'b1010;
      2'd3:    return 4'b1001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic expect_out(input logic [3:0] exp, input int req, input string what);
    logic [3:0] act;
    act = {rsp_valid, rsp_hit, rsp_reload, rsp_recover};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    alloc_valid = v.av;  alloc_reg = v.areg; alloc_addr = v.aaddr;
    store_valid = v.sv;  store_addr = v.saddr;
    chk_valid = v.cv;    chk_reg = v.creg;   chk_recover = v.crec;
    @(posedge clk);
    @(negedge clk);
  endtask

  localparam vec_t IDLE = '{1'b0, 6'd0, 16'h0, 1'b0, 16'h0, 1'b0, 6'd0, 1'b0, 2'd0, 4'd0};

  initial begin
    repeat (3) @(negedge clk);
    expect_out(4'b0000, 1, "outputs in reset");   // R1
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(4'b0000, 1, "outputs after reset"); // R1

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      expect_out(expand(VECS[i].exp), int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R1: reset empties a live entry
    apply('{1'b1, 6'd4, 16'h0400, 1'b0, 16'h0, 1'b0, 6'd0, 1'b0, 2'd0, 4'd0});
    apply(IDLE);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    apply('{1'b0, 6'd0, 16'h0, 1'b0, 16'h0, 1'b1, 6'd4, 1'b0, 2'd0, 4'd0});
    expect_out(4'b1010, 1, "check after mid-run reset");

    // R5: same slot, other tag allocated, old register misses and new one hits
    apply('{1'b1, 6'd12, 16'h0C00, 1'b0, 16'h0, 1'b0, 6'd0, 1'b0, 2'd0, 4'd0});
    apply('{1'b1, 6'd0,  16'h0D00, 1'b0, 16'h0, 1'b0, 6'd0, 1'b0, 2'd0, 4'd0});
    apply('{1'b0, 6'd0, 16'h0, 1'b0, 16'h0, 1'b1, 6'd12, 1'b1, 2'd0, 4'd0});
    expect_out(4'b1001, 5, "replaced tag misses");
    apply('{1'b0, 6'd0, 16'h0, 1'b1, 16'h0C00, 1'b1, 6'd0, 1'b0, 2'd0, 4'd0});
    expect_out(4'b1100, 4, "store to other address, hit");
    apply(IDLE);
    expect_out(4'b0000, 12, "quiet after hit");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule